// File: doc/BRIEF.md
# VLAN Tag Frame Detector

This block watches the byte stream of a received Ethernet frame and tells, once the frame ends, whether the frame carries an IEEE 802.1Q tag equal to a 16-bit identifier that software has programmed. It checks two fixed byte positions for the tag protocol identifier 0x8100. It checks the two bytes that follow them against the programmed identifier. Rejecting the frame is left to the logic that reads the status.

Bytes arrive one per cycle while `rx_valid` is high. `rx_sof` marks the first destination-address byte and `rx_eof` marks the last byte. The identifier sits in a small register with its own write strobe and a read-back output. The detector takes a copy of the identifier when a frame starts, so a write made while a frame is in flight only takes effect from the next frame. One cycle after the final byte, a one-cycle status strobe comes out together with the match bit.

Top module: `vlan_tag_detect`

## Requirements
- R1: After reset the identifier register `tag_q` reads 0x0000. A cycle with `tag_we` high loads `tag_wdata` into it, and the new value is visible on the next cycle.
- R2: The byte accepted with `rx_valid` and `rx_sof` both high is byte 1 of a frame. Every later byte accepted with `rx_valid` high increments the position by one.
- R3: Byte 13 must equal 0x81 and byte 14 must equal 0x00. Byte 13 is the most significant byte, and any other value in either position gives no match.
- R4: Byte 15 must equal bits 15:8 of the identifier captured for the frame, and byte 16 must equal bits 7:0. Any difference gives no match.
- R5: On the cycle after the byte carrying `rx_eof` is accepted, `stat_valid` is high. `stat_vlan` is high on that cycle exactly when R3 and R4 both hold.
- R6: A frame whose last byte comes before byte 16 reports `stat_vlan` = 0, even when all the bytes it has match. A frame of exactly 16 bytes can match.
- R7: `stat_valid` is high for one cycle per frame end. `stat_vlan` keeps its value after that cycle and drops to 0 on the cycle after the next start-of-frame byte is accepted.
- R8: The identifier used for a frame is the value `tag_q` held on the cycle its start-of-frame byte was accepted. A write during the frame, including in that same cycle, does not change that frame's result.
- R9: Cycles with `rx_valid` low do not advance the position and do not affect the result, whatever `rx_data`, `rx_sof` and `rx_eof` carry on those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A receive byte is present this cycle |
| rx_sof | input | 1 | The present byte is the first of a frame |
| rx_eof | input | 1 | The present byte is the last of a frame |
| rx_data | input | 8 | Receive byte |
| tag_we | input | 1 | Write strobe for the identifier register |
| tag_wdata | input | 16 | Identifier value to write |
| tag_q | output | 16 | Identifier register read-back |
| stat_valid | output | 1 | One-cycle strobe that the frame status is ready |
| stat_vlan | output | 1 | The frame carried the tag protocol identifier and a matching identifier |

## Verification
The bench builds the block with its default parameters: the type field at byte 13 and the tag protocol identifier 0x8100. With these values, the 15- and 16-byte frames sit exactly on the boundary at which a match becomes possible. The 16-bit identifier can be set to both zero and non-zero values, and each half of the identifier and of the type field can be corrupted or byte-swapped separately. Idle cycles carrying fake frame markers are placed inside frames, and an identifier write is placed in the middle of a frame and in the same cycle as a start-of-frame.

// File: rtl/vlan_tag_detect.sv
module vlan_tag_detect #(
  parameter int          TYPE_POS = 13,
  parameter logic [15:0] TPID     = 16'h8100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic        rx_sof,
  input  logic        rx_eof,
  input  logic [7:0]  rx_data,
  input  logic        tag_we,
  input  logic [15:0] tag_wdata,
  output logic [15:0] tag_q,
  output logic        stat_valid,
  output logic        stat_vlan
);
  localparam int LAST  = TYPE_POS + 3;
  localparam int CNT_W = $clog2(LAST + 2) + 1;
  localparam logic [CNT_W-1:0] P_T0  = CNT_W'(TYPE_POS);
  localparam logic [CNT_W-1:0] P_T1  = CNT_W'(TYPE_POS + 1);
  localparam logic [CNT_W-1:0] P_V0  = CNT_W'(TYPE_POS + 2);
  localparam logic [CNT_W-1:0] P_V1  = CNT_W'(LAST);
  localparam logic [CNT_W-1:0] P_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt, pos;
  logic [15:0]      ftag, ftag_cur;
  logic             in_frame, ok, ok_nxt, beat, chk;
  logic [7:0]       exp_byte;

  assign beat     = rx_valid && (rx_sof || in_frame);
  assign pos      = rx_sof ? P_ONE : cnt + P_ONE;
  assign ftag_cur = rx_sof ? tag_q : ftag;

  always_comb begin
    chk      = 1'b1;
    exp_byte = 8'h00;
    if (pos == P_T0)      exp_byte = TPID[15:8];
    else if (pos == P_T1) exp_byte = TPID[7:0];
    else if (pos == P_V0) exp_byte = ftag_cur[15:8];
    else if (pos == P_V1) exp_byte = ftag_cur[7:0];
    else                  chk = 1'b0;
  end

  assign ok_nxt = (rx_sof || ok) && (!chk || rx_data == exp_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tag_q <= '0;
    else if (tag_we) tag_q <= tag_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      ftag       <= '0;
      in_frame   <= 1'b0;
      ok         <= 1'b0;
      stat_valid <= 1'b0;
      stat_vlan  <= 1'b0;
    end else begin
      stat_valid <= beat && rx_eof;
      if (beat) begin
        ftag     <= ftag_cur;
        ok       <= ok_nxt;
        in_frame <= !rx_eof;
        cnt      <= (pos >= P_V1) ? P_V1 : pos;
        if (rx_eof)      stat_vlan <= ok_nxt && (pos >= P_V1);
        else if (rx_sof) stat_vlan <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vlan_tag_detect_chk.sv
module vlan_tag_detect_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_valid,
  input logic        rx_sof,
  input logic        rx_eof,
  input logic        tag_we,
  input logic [15:0] tag_wdata,
  input logic [15:0] tag_q,
  input logic        stat_valid,
  input logic        stat_vlan
);
  a_r1_tag_load: assert property (@(posedge clk) disable iff (!rst_n)
    tag_we |=> tag_q == $past(tag_wdata));
  a_r1_tag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tag_we |=> $stable(tag_q));
  a_r5_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_eof) |=> !stat_valid);
  a_r7_rise_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_vlan) |-> stat_valid);
  a_r7_sof_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_sof && !rx_eof) |=> !stat_vlan);
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |=> !stat_valid && $stable(stat_vlan));
endmodule

bind vlan_tag_detect vlan_tag_detect_chk u_chk (.*);

// File: tb/test_vlan_tag_detect.sv
module test_vlan_tag_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        tag_we = 1'b0;
  logic [15:0] tag_wdata = 16'h0000;
  logic [15:0] tag_q;
  logic        stat_valid, stat_vlan;

  int nvec = 0, nfail = 0;
  logic [7:0] fr [64];

  always #2 clk = ~clk;

  vlan_tag_detect i_vlan_tag_detect (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic build(input logic [15:0] tpid, input logic [15:0] tag);
    for (int i = 0; i < 64; i++) fr[i] = 8'(i * 7 + 3);
    fr[12] = tpid[15:8]; fr[13] = tpid[7:0];
    fr[14] = tag[15:8];  fr[15] = tag[7:0];
  endtask

  task automatic write_tag(input logic [15:0] v);
    @(negedge clk); tag_we = 1'b1; tag_wdata = v;
    @(negedge clk); tag_we = 1'b0;
  endtask

  task automatic send(input int len, input bit gaps, input int wr_idx, input logic [15:0] wr_val,
                      input bit exp, input string req);
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b1; rx_eof = 1'b1; rx_data = 8'h5A;
      end
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == len - 1); rx_data = fr[i];
      tag_we = (i == wr_idx); tag_wdata = wr_val;
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; tag_we = 1'b0;
    check(stat_valid == 1'b1, {req, " strobe"}, stat_valid, 1);
    check(stat_vlan == exp, req, stat_vlan, exp);
    @(negedge clk);
    check(stat_valid == 1'b0, "R7 strobe one cycle", stat_valid, 0);
    check(stat_vlan == exp, "R7 bit held", stat_vlan, exp);
  endtask

  task automatic t_reset();
    check(tag_q == 16'h0000, "R1 reset tag", tag_q, 0);
    check(stat_valid == 1'b0, "R5 reset strobe", stat_valid, 0);
    check(stat_vlan == 1'b0, "R5 reset bit", stat_vlan, 0);
    write_tag(16'h0ABC);
    check(tag_q == 16'h0ABC, "R1 write", tag_q, 16'h0ABC);
  endtask

  task automatic t_match();
    build(16'h8100, 16'h0ABC); send(64, 0, -1, 0, 1, "R5 R3 R4 R2 match 64");
    build(16'h8800, 16'h0ABC); send(64, 0, -1, 0, 0, "R3 wrong type");
    build(16'h0081, 16'h0ABC); send(64, 0, -1, 0, 0, "R3 type swapped");
    build(16'h8101, 16'h0ABC); send(64, 0, -1, 0, 0, "R3 low type byte");
    build(16'h8100, 16'h0ABD); send(64, 0, -1, 0, 0, "R4 low tag byte");
    build(16'h8100, 16'h1ABC); send(64, 0, -1, 0, 0, "R4 high tag byte");
    build(16'h8100, 16'hBC0A); send(64, 0, -1, 0, 0, "R4 tag swapped");
  endtask

  task automatic t_length();
    build(16'h8100, 16'h0ABC);
    send(15, 0, -1, 0, 0, "R6 15 bytes");
    send(16, 0, -1, 0, 1, "R6 16 bytes");
    send(14, 0, -1, 0, 0, "R6 14 bytes");
    send(1, 0, -1, 0, 0, "R6 single byte");
  endtask

  task automatic t_sof_clear();
    build(16'h8100, 16'h0ABC); send(20, 0, -1, 0, 1, "R7 setup");
    @(negedge clk); rx_valid = 1'b1; rx_sof = 1'b1; rx_eof = 1'b0; rx_data = 8'h11;
    @(negedge clk); rx_valid = 1'b0; rx_sof = 1'b0;
    check(stat_vlan == 1'b0, "R7 cleared at sof", stat_vlan, 0);
    check(stat_valid == 1'b0, "R7 no strobe at sof", stat_valid, 0);
    send(20, 0, -1, 0, 1, "R7 restarted frame");
  endtask

  task automatic t_midwrite();
    build(16'h8100, 16'h0ABC);
    send(40, 0, 5, 16'h1234, 1, "R8 write mid frame");
    check(tag_q == 16'h1234, "R8 write landed", tag_q, 16'h1234);
    send(40, 0, -1, 0, 0, "R8 old tag after write");
    build(16'h8100, 16'h1234);
    send(40, 0, 0, 16'h0ABC, 1, "R8 write at sof");
    build(16'h8100, 16'h0ABC);
    send(40, 0, -1, 0, 1, "R8 new tag next frame");
  endtask

  task automatic t_gaps();
    build(16'h8100, 16'h0ABC); send(30, 1, -1, 0, 1, "R9 gaps match");
    send(15, 1, -1, 0, 0, "R9 gaps short");
    write_tag(16'h0000);
    build(16'h8100, 16'h0000); send(17, 1, -1, 0, 1, "R4 zero tag");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_match();
    t_length();
    t_sof_clear();
    t_midwrite();
    t_gaps();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nvec++; nfail++;
    $display("FAIL watchdog R5 actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule